// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This peripheral guards a system against software that stops making progress. It holds a 64-bit up-counter, kept as two 32-bit halves, and a 64-bit period register, all on a small 32-bit register bus with address, write strobe, read strobe, write data and registered read data. While the block is idle, software loads the counter, the period, a timer-control mode field and a global-control field. It then arms the watchdog by writing two 16-bit keys in order to the watchdog-control register. From that point the configuration is frozen and only the key field of the watchdog-control register is still decoded.

Once running, software keeps the watchdog alive by writing the same two keys again. The second key of that pair clears the count. If the count climbs to the period, the block sets a sticky timeout flag and raises a one-cycle reset request. A key that does not match the one expected while running also raises the reset request at once. After either event the block rests in a tripped state until its own reset. Reads of the high counter half return a copy taken when the low half was last read, so software can read a 64-bit value in two steps and get halves that belong together.

States: IDLE (configurable), ARMING (first key taken, configuration locked), RUNNING (counting), SERVICING (first keep-alive key taken, still counting), TRIPPED (terminal). Transitions: IDLE→ARMING on the first key with enable set; ARMING→RUNNING on the second key with enable set; RUNNING→SERVICING on the first key; SERVICING→RUNNING on the second key, which clears the count; RUNNING or SERVICING→TRIPPED on a mismatched key or on the period match.

Top module: `wdg64_keyed`

## Requirements
- R1: After reset every register reads 0, the state is IDLE, and the reset request and the timeout flag are low.
- R2: Register offsets are 0x10 counter low, 0x14 counter high (snapshot), 0x18 period low, 0x1C period high, 0x20 timer control (mode in bits 7:6), 0x24 global control (bits 3:0), 0x28 watchdog control. In IDLE each of these is writable and reads back, with unused bits reading 0.
- R3: In watchdog control, the key is in bits 31:16 and the enable is bit 14. Key 0xA5C6 with enable set moves IDLE to ARMING. Key 0xDA7E with enable set then moves ARMING to RUNNING.
- R4: In any state other than IDLE, writes to the counter halves, the period halves, timer control and global control leave their values unchanged.
- R5: The counter advances by one per cycle only in RUNNING or SERVICING with global-control bits 3:2 = 2, bits 1 and 0 both set, and timer-control bits 7:6 = 2. Otherwise it holds.
- R6: While global-control bit 0 (or bit 1) is 0, the low (or high) counter half is held at zero and writes to it are ignored.
- R7: While counting, on the edge where the 64-bit count equals the period, the timeout flag is set and the reset request pulses. From a zero count, this happens P+1 edges after the arming edge, and the count stays at P.
- R8: In RUNNING, key 0xA5C6 followed by key 0xDA7E services the watchdog, and the count restarts from zero on the second key's edge. The enable bit is not needed for these keys.
- R9: In RUNNING or SERVICING, writing any key other than the expected one raises the reset request on that write's edge, without setting the timeout flag.
- R10: The reset request lasts exactly one cycle. The timeout flag then stays set, and TRIPPED ignores all later keys without further pulses.
- R11: Reading counter low captures the high half at the same edge, and counter-high reads return that capture.
- R12: In IDLE and ARMING, a wrong key or a missing enable bit is ignored, with no state change and no reset request.
- R13: Read data is registered and appears one cycle after the read strobe. Watchdog control reads the timeout flag in bit 15, bit 14 as 1 in any state but IDLE, and the other bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_re |
| rst_req | output | 1 | One-cycle reset request |
| timeout_flag | output | 1 | Sticky period-match flag |

## Verification
A write takes effect on the edge where the strobe is sampled, so the reset request from a mismatched key is checked right after that edge, and it must be gone one cycle later. The timeout is counted from the edge that takes the second arming key, or the second service key. For a period P, the flag and the pulse are expected exactly P+1 edges later, and both are checked as still low after P edges. Read data is due one cycle after the strobe. A scoreboard queues the expected value with each read and compares it at the falling edge after the read is captured. This timing also lets the snapshot read of the high half be checked after the live half has moved on.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMING  = 3'd1,
        ST_RUNNING = 3'd2,
        ST_SERVING = 3'd3,
        ST_TRIPPED = 3'd4
    } wdg_state_e;

    // byte offsets of the register window
    localparam int unsigned OFS_CNT_LO = 32'h10;
    localparam int unsigned OFS_CNT_HI = 32'h14;
    localparam int unsigned OFS_PRD_LO = 32'h18;
    localparam int unsigned OFS_PRD_HI = 32'h1C;
    localparam int unsigned OFS_TMODE  = 32'h20;
    localparam int unsigned OFS_GCTL   = 32'h24;
    localparam int unsigned OFS_WDCTL  = 32'h28;

    // watchdog-control field positions
    localparam int unsigned KEY_LSB  = 16;
    localparam int unsigned FLAG_BIT = 15;
    localparam int unsigned EN_BIT   = 14;

    // mode field positions and required values
    localparam int unsigned TMODE_LSB  = 6;
    localparam logic [1:0]  TMODE_CONT = 2'd2;
    localparam logic [1:0]  GMODE_WDOG = 2'd2;

endpackage

// File: rtl/wdg_cfg.sv
module wdg_cfg #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic [1:0]        wr_prd,
    input  logic              wr_tmode,
    input  logic              wr_gctl,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        tmode_in,
    input  logic [3:0]        gctl_in,
    output logic [CNT_W-1:0]  period,
    output logic [1:0]        tmode,
    output logic [3:0]        gctl
);

    logic [DATA_W-1:0] prd_half [2];

    for (genvar h = 0; h < 2; h++) begin : g_prd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prd_half[h] <= '0;
            end else if (wr_prd[h] && !locked) begin
                prd_half[h] <= wdata;
            end
        end

        // R4: period frozen once locked
        a_r4_prd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (locked && wr_prd[h]) |=> $stable(prd_half[h]));
    end

    assign period = {prd_half[1], prd_half[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmode <= '0;
            gctl  <= '0;
        end else if (!locked) begin
            if (wr_tmode) tmode <= tmode_in;
            if (wr_gctl)  gctl  <= gctl_in;
        end
    end

    // R4: control fields frozen once locked
    a_r4_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && (wr_tmode || wr_gctl)) |=> ($stable(tmode) && $stable(gctl)));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic [1:0]        wr_cnt,
    input  logic [1:0]        half_rel,
    input  logic              run,
    input  logic              restart,
    input  logic              rd_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  period,
    output logic [DATA_W-1:0] cnt_lo,
    output logic [DATA_W-1:0] snap_hi,
    output logic              hit
);

    logic [DATA_W-1:0] half_q [2];
    logic [CNT_W-1:0]  cnt_full;
    logic [CNT_W-1:0]  cnt_inc;

    assign cnt_full = {half_q[1], half_q[0]};
    assign cnt_inc  = cnt_full + CNT_W'(1);
    assign hit      = run && (cnt_full == period);

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q[h] <= '0;
            end else if (restart) begin
                half_q[h] <= '0;
            end else if (run) begin
                if (!hit) half_q[h] <= cnt_inc[h*DATA_W +: DATA_W];
            end else if (!locked) begin
                if (!half_rel[h])   half_q[h] <= '0;
                else if (wr_cnt[h]) half_q[h] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     snap_hi <= '0;
        else if (rd_lo) snap_hi <= half_q[1];
    end

    assign cnt_lo = half_q[0];

    // R8: a service restart leaves a zero count
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_full == '0));

    // R7: the count stops at the period value
    a_r7_hold_at_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> $stable(cnt_full));

    // R5: no movement while locked and not counting
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !run && !restart) |=> $stable(cnt_full));

    // R6: a half held in reset reads zero
    a_r6_half_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !half_rel[0]) |=> (half_q[0] == '0));

endmodule

// File: rtl/wdg_keyfsm.sv
module wdg_keyfsm
    import wdg_pkg::*;
#(
    parameter int unsigned KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key,
    input  logic             en_bit,
    input  logic             hit,
    output logic             locked,
    output logic             live,
    output logic             restart,
    output logic             rst_req,
    output logic             flag
);

    wdg_state_e st, nxt;
    logic       trip_now;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:
                if (key_wr && en_bit && key == KEY_ARM) nxt = ST_ARMING;
            ST_ARMING:
                if (key_wr && en_bit && key == KEY_GO) nxt = ST_RUNNING;
            ST_RUNNING:
                if (hit)         nxt = ST_TRIPPED;
                else if (key_wr) nxt = (key == KEY_ARM) ? ST_SERVING : ST_TRIPPED;
            ST_SERVING:
                if (hit)         nxt = ST_TRIPPED;
                else if (key_wr) nxt = (key == KEY_GO) ? ST_RUNNING : ST_TRIPPED;
            ST_TRIPPED:
                nxt = ST_TRIPPED;
            default:
                nxt = ST_TRIPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    assign trip_now = (nxt == ST_TRIPPED) && (st != ST_TRIPPED);
    assign locked   = (st != ST_IDLE);
    assign live     = (st == ST_RUNNING) || (st == ST_SERVING);
    assign restart  = (st == ST_SERVING) && key_wr && (key == KEY_GO) && !hit;

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            flag    <= 1'b0;
        end else begin
            rst_req <= trip_now;
            if (live && hit) flag <= 1'b1;
        end
    end

    // R10: single-cycle request
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R10: flag is sticky
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);

    // R10: tripped is terminal
    a_r10_trip_final: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRIPPED) |=> (st == ST_TRIPPED));

    // R7: period match sets flag and pulses request
    a_r7_match_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (live && hit) |=> (flag && rst_req));

    // R9: mismatched key while running pulses without flag
    a_r9_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RUNNING) && key_wr && key != KEY_ARM && !hit) |=> (rst_req && !flag));

    // R3: first key with enable arms
    a_r3_arm_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && key_wr && en_bit && key == KEY_ARM) |=> (st == ST_ARMING));

    // R12: no request outside counting states
    a_r12_quiet_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (!live) |=> !rst_req);

endmodule

// File: rtl/wdg64_keyed.sv
module wdg64_keyed
    import wdg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned KEY_W   = 16,
    parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_GO  = 16'hDA7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              timeout_flag
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic sel_cnt_lo, sel_cnt_hi, sel_prd_lo, sel_prd_hi;
    logic sel_tmode, sel_gctl, sel_wdctl;

    assign sel_cnt_lo = (bus_addr == ADDR_W'(OFS_CNT_LO));
    assign sel_cnt_hi = (bus_addr == ADDR_W'(OFS_CNT_HI));
    assign sel_prd_lo = (bus_addr == ADDR_W'(OFS_PRD_LO));
    assign sel_prd_hi = (bus_addr == ADDR_W'(OFS_PRD_HI));
    assign sel_tmode  = (bus_addr == ADDR_W'(OFS_TMODE));
    assign sel_gctl   = (bus_addr == ADDR_W'(OFS_GCTL));
    assign sel_wdctl  = (bus_addr == ADDR_W'(OFS_WDCTL));

    logic              locked, live, restart, hit, run, cfg_ok;
    logic [CNT_W-1:0]  period;
    logic [1:0]        tmode;
    logic [3:0]        gctl;
    logic [DATA_W-1:0] cnt_lo, snap_hi;
    logic [DATA_W-1:0] rd_mux;

    wdg_keyfsm #(
        .KEY_W   (KEY_W),
        .KEY_ARM (KEY_ARM),
        .KEY_GO  (KEY_GO)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (bus_we && sel_wdctl),
        .key     (bus_wdata[KEY_LSB +: KEY_W]),
        .en_bit  (bus_wdata[EN_BIT]),
        .hit     (hit),
        .locked  (locked),
        .live    (live),
        .restart (restart),
        .rst_req (rst_req),
        .flag    (timeout_flag)
    );

    wdg_cfg #(
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (locked),
        .wr_prd   ({bus_we && sel_prd_hi, bus_we && sel_prd_lo}),
        .wr_tmode (bus_we && sel_tmode),
        .wr_gctl  (bus_we && sel_gctl),
        .wdata    (bus_wdata),
        .tmode_in (bus_wdata[TMODE_LSB +: 2]),
        .gctl_in  (bus_wdata[3:0]),
        .period   (period),
        .tmode    (tmode),
        .gctl     (gctl)
    );

    assign cfg_ok = (gctl[3:2] == GMODE_WDOG) && gctl[0] && gctl[1] && (tmode == TMODE_CONT);
    assign run    = live && cfg_ok;

    wdg_counter #(
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (locked),
        .wr_cnt   ({bus_we && sel_cnt_hi, bus_we && sel_cnt_lo}),
        .half_rel (gctl[1:0]),
        .run      (run),
        .restart  (restart),
        .rd_lo    (bus_re && sel_cnt_lo),
        .wdata    (bus_wdata),
        .period   (period),
        .cnt_lo   (cnt_lo),
        .snap_hi  (snap_hi),
        .hit      (hit)
    );

    always_comb begin
        rd_mux = '0;
        if (sel_cnt_lo)      rd_mux = cnt_lo;
        else if (sel_cnt_hi) rd_mux = snap_hi;
        else if (sel_prd_lo) rd_mux = period[DATA_W-1:0];
        else if (sel_prd_hi) rd_mux = period[CNT_W-1:DATA_W];
        else if (sel_tmode)  rd_mux[TMODE_LSB +: 2] = tmode;
        else if (sel_gctl)   rd_mux[3:0] = gctl;
        else if (sel_wdctl) begin
            rd_mux[FLAG_BIT] = timeout_flag;
            rd_mux[EN_BIT]   = locked;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    // R13: read data only changes after a read strobe
    a_r13_rd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/wdg64_keyed_bench.sv
module wdg64_keyed_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    logic        timeout_flag;

    int n_run = 0;
    int n_fail = 0;
    int rst_cnt = 0;
    bit done = 1'b0;

    logic [31:0] q_exp[$];
    string       q_tag[$];

    localparam logic [5:0] A_CLO = 6'h10, A_CHI = 6'h14, A_PLO = 6'h18, A_PHI = 6'h1C;
    localparam logic [5:0] A_TM = 6'h20, A_GC = 6'h24, A_WD = 6'h28;
    localparam logic [31:0] K_ARM = 32'hA5C6_4000, K_GO = 32'hDA7E_4000;

    always #5 clk = ~clk;

    wdg64_keyed u_wdg64_keyed (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_re (bus_re), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .rst_req (rst_req), .timeout_flag (timeout_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each queued read one cycle after its strobe
    initial forever begin
        @(posedge clk);
        if (bus_re) begin
            @(negedge clk);
            if (q_exp.size() > 0) chk(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
        end
    end

    always @(posedge clk) if (rst_req) rst_cnt <= rst_cnt + 1;

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_get(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(input logic [31:0] plo, input logic [31:0] phi, input logic [31:0] clo,
                         input logic [31:0] chi, input logic [31:0] gc, input logic [31:0] tm);
        wr(A_GC, gc); wr(A_TM, tm);
        wr(A_PLO, plo); wr(A_PHI, phi);
        wr(A_CLO, clo); wr(A_CHI, chi);
    endtask

    task automatic arm();
        wr(A_WD, K_ARM); wr(A_WD, K_GO);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base;
        do_reset();

        // R1: reset state
        chk("R1 rst_req", {31'b0, rst_req}, 0);
        chk("R1 flag", {31'b0, timeout_flag}, 0);
        rd_exp(A_CLO, 0, "R1 cnt lo");
        rd_exp(A_PHI, 0, "R1 prd hi");
        rd_exp(A_WD, 0, "R1 wdctl");

        // R2: readback in IDLE
        wr(A_PLO, 32'h1234_5678);
        rd_exp(A_PLO, 32'h1234_5678, "R2 prd lo");
        wr(A_TM, 32'hFFFF_FFFF);
        rd_exp(A_TM, 32'h0000_00C0, "R2 tmode field");
        wr(A_GC, 32'hFFFF_FFFF);
        rd_exp(A_GC, 32'h0000_000F, "R2 gctl field");

        // R12: IDLE ignores missing enable and wrong first key
        wr(A_WD, 32'hA5C6_0000);
        rd_exp(A_WD, 0, "R12 no enable stays idle");
        wr(A_WD, K_GO);
        rd_exp(A_WD, 0, "R12 wrong key stays idle");
        // R3: arming step one
        wr(A_WD, K_ARM);
        rd_exp(A_WD, 32'h0000_4000, "R3 arming state");
        // R4: configuration locked
        wr(A_PLO, 32'hDEAD_BEEF);
        rd_exp(A_PLO, 32'h1234_5678, "R4 period locked");
        wr(A_GC, 32'h0);
        rd_exp(A_GC, 32'h0000_000F, "R4 gctl locked");
        wr(A_CLO, 32'h55);
        rd_exp(A_CLO, 0, "R4 counter locked");
        // R12: wrong key in ARMING ignored
        base = rst_cnt;
        wr(A_WD, 32'h1111_4000);
        repeat (2) @(negedge clk);
        chk("R12 no request in arming", rst_cnt - base, 0);
        rd_exp(A_WD, 32'h0000_4000, "R12 still arming");

        // R7 / R10: exact timeout
        do_reset();
        setup(20, 0, 0, 0, 32'hB, 32'h80);
        arm();
        repeat (20) @(negedge clk);
        chk("R7 no flag at P", {31'b0, timeout_flag}, 0);
        chk("R7 no request at P", {31'b0, rst_req}, 0);
        @(negedge clk);
        chk("R7 flag at P+1", {31'b0, timeout_flag}, 1);
        chk("R7 request at P+1", {31'b0, rst_req}, 1);
        @(negedge clk);
        chk("R10 request one cycle", {31'b0, rst_req}, 0);
        rd_exp(A_CLO, 20, "R7 count held at period");
        rd_exp(A_WD, 32'h0000_C000, "R13 wdctl flag and armed");
        base = rst_cnt;
        chk("R10 single pulse", base, 1);
        wr(A_WD, K_ARM); wr(A_WD, 32'h0101_0000); wr(A_WD, K_GO);
        repeat (2) @(negedge clk);
        chk("R10 tripped ignores keys", rst_cnt - base, 0);
        chk("R10 flag sticky", {31'b0, timeout_flag}, 1);

        // R8: service restarts the count
        do_reset();
        setup(30, 0, 0, 0, 32'hB, 32'h80);
        arm();
        repeat (20) @(negedge clk);
        wr(A_WD, 32'hA5C6_0000);
        wr(A_WD, 32'hDA7E_0000);
        repeat (30) @(negedge clk);
        chk("R8 no trip at P after service", {31'b0, rst_req}, 0);
        @(negedge clk);
        chk("R8 trip at P+1 after service", {31'b0, rst_req}, 1);

        // R9: wrong key while running
        do_reset();
        setup(32'hFFFF, 0, 0, 0, 32'hB, 32'h80);
        arm();
        wr(A_WD, 32'h1234_0000);
        chk("R9 request on bad key", {31'b0, rst_req}, 1);
        chk("R9 no flag on bad key", {31'b0, timeout_flag}, 0);
        @(negedge clk);
        chk("R10 request drops", {31'b0, rst_req}, 0);
        rd_exp(A_WD, 32'h0000_4000, "R9 wdctl after bad key");

        // R9: wrong key while servicing
        do_reset();
        setup(32'hFFFF, 0, 0, 0, 32'hB, 32'h80);
        arm();
        wr(A_WD, 32'hA5C6_0000);
        wr(A_WD, 32'h5555_0000);
        chk("R9 request on bad second key", {31'b0, rst_req}, 1);

        // R5: counting needs watchdog mode and continuous mode
        do_reset();
        setup(10, 0, 0, 0, 32'h3, 32'h80);
        arm();
        repeat (15) @(negedge clk);
        rd_exp(A_CLO, 0, "R5 no count without wdog mode");
        chk("R5 no timeout without wdog mode", {31'b0, timeout_flag}, 0);
        do_reset();
        setup(10, 0, 0, 0, 32'hB, 32'h40);
        arm();
        repeat (15) @(negedge clk);
        rd_exp(A_CLO, 0, "R5 no count in one-shot mode");

        // R6: half held in reset
        do_reset();
        wr(A_GC, 32'hA);
        wr(A_CLO, 32'h77);
        wr(A_CHI, 32'h99);
        rd_exp(A_CLO, 0, "R6 low half held");
        rd_exp(A_CHI, 32'h99, "R6 high half released");

        // R11: high-half snapshot
        do_reset();
        setup(0, 32'h100, 32'hFFFF_FFFE, 5, 32'hB, 32'h80);
        arm();
        rd_get(A_CLO, v);
        repeat (4) @(negedge clk);
        rd_exp(A_CHI, (v >= 32'hFFFF_FFFE) ? 32'd5 : 32'd6, "R11 snapshot matches low read");
        rd_get(A_CLO, v);
        rd_exp(A_CHI, 32'd6, "R11 snapshot after wrap");

        repeat (3) @(negedge clk);
        if (q_exp.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R13 reads left unanswered actual=%0d expected=0", q_exp.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule